// File: doc/BRIEF.md
# Frame Buffer Free-List Manager

This block keeps track of which fixed-size blocks of a shared frame buffer are unused. The buffer is divided into `NUM_BLOCKS` blocks of `BLOCK_BYTES` bytes each. The unused blocks are chained into one linked free list. The links live in an internal next-pointer table indexed by block number. The list behaves as a last-in, first-out stack with a head register and a count register. After reset a hardware sweep writes every link, and the list then holds all blocks.

Ingress ports ask for a buffer handle by raising their request bit. A round-robin arbiter serves one eligible port per cycle, and the grant comes back one cycle later together with the block number. A departing frame returns its block through a single release port, and the block goes back on top of the list.

Each port may hold only a limited number of blocks. The standard limit covers the largest normal frame, and a per-port enable raises it to cover oversized frames. A shared reserve keeps the last few blocks for ports that currently hold none. A request that is refused raises that port's flow-control flag. A release that would overfill the list sets a sticky error flag.

Top module: `fl_buffer_mgr`

## Requirements
- R1: After reset, `ready_o` stays low during the initialization sweep, which lasts `NUM_BLOCKS` cycles. It then rises with `free_count_o` equal to `NUM_BLOCKS` (64). Requests made before `ready_o` is high get no grant and no flow-control flag.
- R2: After initialization, grants hand out block numbers in ascending order starting at 0. A released block is the next block handed out (last in, first out).
- R3: A port is granted by a one-cycle pulse on bit p of `gnt_o`, together with `gnt_handle_o`, in the cycle after its request was sampled. At most one bit of `gnt_o` is set in any cycle.
- R4: Among eligible requesters, the search starts at the port after the last winner. After reset, port 0 has the highest priority.
- R5: A port holding `ceil(1522/128)` = 12 blocks is refused further blocks. While its `big_en_i` bit is 1, the limit is 4096/128 = 32 blocks.
- R6: When `free_count_o` is at or below `RESERVE_BLOCKS` (8), a port holding at least one block is refused. A port holding none is still served while any block is free.
- R7: `fc_o[p]` is high in the cycle after a request from port p was refused while `ready_o` was high, and low otherwise.
- R8: A release with `rel_valid_i` high pushes `rel_handle_i` onto the list. `free_count_o` rises by one, and the block count of port `rel_port_i` falls by one.
- R9: A grant and a release in the same cycle both take effect. The grant carries the previous head of the list, the released block becomes the new head, and `free_count_o` is unchanged.
- R10: A release while `free_count_o` equals `NUM_BLOCKS` sets `err_o`, which stays high until reset. The list and the count are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_PORTS | Per-port block request |
| big_en_i | input | NUM_PORTS | Per-port enable for the oversized-frame limit |
| rel_valid_i | input | 1 | Release strobe |
| rel_port_i | input | $clog2(NUM_PORTS) | Port that held the released block |
| rel_handle_i | input | $clog2(NUM_BLOCKS) | Released block number |
| ready_o | output | 1 | Initialization sweep finished |
| gnt_o | output | NUM_PORTS | One-hot grant pulse |
| gnt_handle_o | output | $clog2(NUM_BLOCKS) | Block number granted |
| fc_o | output | NUM_PORTS | Per-port refusal (flow-control) flag |
| free_count_o | output | $clog2(NUM_BLOCKS+1) | Blocks on the free list |
| err_o | output | 1 | Sticky release-overflow error |

## Verification
A pop for a grant and a push for a release can land on the stack in the same cycle. The stimulus table provokes this by driving a request from port 0 together with the release of a block that port 1 holds. The bench then judges two things. The grant must carry the block that was on top before the release. The very next grant, to port 3, must return the released block, which shows that the release was linked in above the remaining list and that the free count stayed level.

// File: rtl/fl_pkg.sv
package fl_pkg;

  // Number of blocks needed to hold a frame of the given size.
  function automatic int unsigned blocks_for(input int unsigned bytes,
                                             input int unsigned blk_bytes);
    return (bytes + blk_bytes - 1) / blk_bytes;
  endfunction

  // Per-port holding limit chosen by the oversize enable.
  function automatic int unsigned port_limit(input logic big,
                                             input int unsigned std_blocks,
                                             input int unsigned big_blocks);
    return big ? big_blocks : std_blocks;
  endfunction

  // A port is served only under its limit, and it keeps off the reserve
  // unless it holds nothing yet.
  function automatic logic may_alloc(input int unsigned held,
                                     input int unsigned limit,
                                     input int unsigned free_cnt,
                                     input int unsigned reserve);
    return (free_cnt != 0) && (held < limit) &&
           ((held == 0) || (free_cnt > reserve));
  endfunction

endpackage

// File: rtl/fl_rr_arb.sv
module fl_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] elig_i,
  output logic [N-1:0] win_o,
  output logic         any_o
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] last_q;
  logic [PW-1:0] win_idx;

  always_comb begin
    logic found;
    found   = 1'b0;
    win_o   = '0;
    win_idx = last_q;
    for (int k = 1; k <= N; k++) begin
      int unsigned s;
      s = (int'(last_q) + k) % N;
      if (!found && elig_i[s]) begin
        found    = 1'b1;
        win_o[s] = 1'b1;
        win_idx  = PW'(s);
      end
    end
    any_o = found;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= PW'(N - 1);
    else if (any_o) last_q <= win_idx;
  end
endmodule

// File: rtl/fl_stack.sv
module fl_stack #(
  parameter int NB = 64,
  parameter int HW = 6,
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop_i,
  input  logic          push_i,
  input  logic [HW-1:0] push_h_i,
  output logic          ready_o,
  output logic [HW-1:0] head_o,
  output logic [CW-1:0] count_o
);
  logic [HW-1:0] next_mem [NB];
  logic [HW-1:0] init_idx;
  logic          ready_q;
  logic [HW-1:0] head_q;
  logic [CW-1:0] count_q;
  logic [HW-1:0] head_next;

  assign head_next = next_mem[head_q];

  // Link table: sweep writes during init, pushes write afterwards.
  always_ff @(posedge clk) begin
    if (!ready_q) begin
      next_mem[init_idx] <= init_idx + HW'(1);
    end else if (push_i) begin
      next_mem[push_h_i] <= pop_i ? head_next : head_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_idx <= '0;
      ready_q  <= 1'b0;
      head_q   <= '0;
      count_q  <= '0;
    end else if (!ready_q) begin
      init_idx <= init_idx + HW'(1);
      if (init_idx == HW'(NB - 1)) begin
        ready_q <= 1'b1;
        head_q  <= '0;
        count_q <= CW'(NB);
      end
    end else begin
      unique case ({pop_i, push_i})
        2'b11:   head_q <= push_h_i;
        2'b10: begin
          head_q  <= head_next;
          count_q <= count_q - CW'(1);
        end
        2'b01: begin
          head_q  <= push_h_i;
          count_q <= count_q + CW'(1);
        end
        default: ;
      endcase
    end
  end

  assign ready_o = ready_q;
  assign head_o  = head_q;
  assign count_o = count_q;
endmodule

// File: rtl/fl_port_acct.sv
module fl_port_acct
  import fl_pkg::*;
#(
  parameter int NP         = 4,
  parameter int PW         = 2,
  parameter int CW         = 7,
  parameter int STD_BLOCKS = 12,
  parameter int BIG_BLOCKS = 32,
  parameter int RESERVE    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ready_i,
  input  logic [NP-1:0] req_i,
  input  logic [NP-1:0] big_en_i,
  input  logic [CW-1:0] free_i,
  input  logic [NP-1:0] grant_i,
  input  logic          rel_i,
  input  logic [PW-1:0] rel_port_i,
  output logic [NP-1:0] elig_o,
  output logic [NP-1:0] deny_o
);
  logic [CW-1:0] held_q [NP];

  for (genvar p = 0; p < NP; p++) begin : g_port
    logic ok;
    logic dec;
    assign ok  = may_alloc(int'(held_q[p]),
                           port_limit(big_en_i[p], STD_BLOCKS, BIG_BLOCKS),
                           int'(free_i), RESERVE);
    assign elig_o[p] = ready_i && req_i[p] && ok;
    assign deny_o[p] = ready_i && req_i[p] && !ok;
    assign dec = rel_i && (rel_port_i == PW'(p)) && (held_q[p] != '0);

    always_ff @(posedge clk) begin
      if (!rst_n) held_q[p] <= '0;
      else if (grant_i[p] && !dec) held_q[p] <= held_q[p] + CW'(1);
      else if (!grant_i[p] && dec) held_q[p] <= held_q[p] - CW'(1);
    end
  end
endmodule

// File: rtl/fl_buffer_mgr.sv
module fl_buffer_mgr
  import fl_pkg::*;
#(
  parameter int NUM_PORTS       = 4,
  parameter int NUM_BLOCKS      = 64,
  parameter int BLOCK_BYTES     = 128,
  parameter int STD_FRAME_BYTES = 1522,
  parameter int BIG_FRAME_BYTES = 4096,
  parameter int RESERVE_BLOCKS  = 8,
  localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int HW = $clog2(NUM_BLOCKS),
  localparam int CW = $clog2(NUM_BLOCKS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] req_i,
  input  logic [NUM_PORTS-1:0] big_en_i,
  input  logic                 rel_valid_i,
  input  logic [PW-1:0]        rel_port_i,
  input  logic [HW-1:0]        rel_handle_i,
  output logic                 ready_o,
  output logic [NUM_PORTS-1:0] gnt_o,
  output logic [HW-1:0]        gnt_handle_o,
  output logic [NUM_PORTS-1:0] fc_o,
  output logic [CW-1:0]        free_count_o,
  output logic                 err_o
);
  localparam int STD_BLOCKS = blocks_for(STD_FRAME_BYTES, BLOCK_BYTES);
  localparam int BIG_BLOCKS = blocks_for(BIG_FRAME_BYTES, BLOCK_BYTES);

  logic                 ready;
  logic [HW-1:0]        head;
  logic [CW-1:0]        count;
  logic [NUM_PORTS-1:0] elig, deny, win;
  logic                 pop_evt, push_evt, ovf_evt;

  assign push_evt = ready && rel_valid_i && (count != CW'(NUM_BLOCKS));
  assign ovf_evt  = ready && rel_valid_i && (count == CW'(NUM_BLOCKS));

  fl_port_acct #(
    .NP(NUM_PORTS), .PW(PW), .CW(CW), .STD_BLOCKS(STD_BLOCKS),
    .BIG_BLOCKS(BIG_BLOCKS), .RESERVE(RESERVE_BLOCKS)
  ) u_acct (
    .clk(clk), .rst_n(rst_n), .ready_i(ready), .req_i(req_i),
    .big_en_i(big_en_i), .free_i(count), .grant_i(win),
    .rel_i(push_evt), .rel_port_i(rel_port_i),
    .elig_o(elig), .deny_o(deny)
  );

  fl_rr_arb #(.N(NUM_PORTS)) u_arb (
    .clk(clk), .rst_n(rst_n), .elig_i(elig), .win_o(win), .any_o(pop_evt)
  );

  fl_stack #(.NB(NUM_BLOCKS), .HW(HW), .CW(CW)) u_stack (
    .clk(clk), .rst_n(rst_n), .pop_i(pop_evt), .push_i(push_evt),
    .push_h_i(rel_handle_i), .ready_o(ready), .head_o(head), .count_o(count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_o        <= '0;
      gnt_handle_o <= '0;
      fc_o         <= '0;
      err_o        <= 1'b0;
    end else begin
      gnt_o <= win;
      fc_o  <= deny;
      if (pop_evt) gnt_handle_o <= head;
      if (ovf_evt) err_o <= 1'b1;
    end
  end

  assign ready_o      = ready;
  assign free_count_o = count;
endmodule

// File: rtl/fl_checker.sv
module fl_checker #(
  parameter int NUM_PORTS  = 4,
  parameter int NUM_BLOCKS = 64,
  parameter int CW         = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ready_o,
  input logic [NUM_PORTS-1:0] gnt_o,
  input logic [NUM_PORTS-1:0] fc_o,
  input logic [CW-1:0]        free_count_o,
  input logic                 err_o,
  input logic                 pop_evt,
  input logic                 push_evt
);
  a_r1_no_grant_in_init: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |-> gnt_o == '0);

  a_r3_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));

  a_r7_fc_excludes_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_o & gnt_o) == '0);

  a_r2_pop_count: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && pop_evt && !push_evt) |=>
      free_count_o == $past(free_count_o) - CW'(1));

  a_r8_push_count: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && push_evt && !pop_evt) |=>
      free_count_o == $past(free_count_o) + CW'(1));

  a_r9_both_level: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && push_evt && pop_evt) |=> $stable(free_count_o));

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    free_count_o <= CW'(NUM_BLOCKS));
endmodule

bind fl_buffer_mgr fl_checker #(
  .NUM_PORTS(NUM_PORTS), .NUM_BLOCKS(NUM_BLOCKS), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ready_o(ready_o), .gnt_o(gnt_o), .fc_o(fc_o),
  .free_count_o(free_count_o), .err_o(err_o), .pop_evt(pop_evt),
  .push_evt(push_evt)
);

// File: tb/sim_fl_buffer_mgr.sv
module sim_fl_buffer_mgr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req_i = '0;
  logic [3:0] big_en_i = '0;
  logic       rel_valid_i = 1'b0;
  logic [1:0] rel_port_i = '0;
  logic [5:0] rel_handle_i = '0;
  logic       ready_o;
  logic [3:0] gnt_o;
  logic [5:0] gnt_handle_o;
  logic [3:0] fc_o;
  logic [6:0] free_count_o;
  logic       err_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  fl_buffer_mgr u0 (.*);

  // {req, rel_valid, rel_port, rel_handle, expected grant, expected handle}
  localparam logic [22:0] VEC [0:8] = '{
    {4'b0001, 1'b0, 2'd0, 6'd0, 4'b0001, 6'd0},
    {4'b0110, 1'b0, 2'd0, 6'd0, 4'b0010, 6'd1},
    {4'b0110, 1'b0, 2'd0, 6'd0, 4'b0100, 6'd2},
    {4'b1111, 1'b0, 2'd0, 6'd0, 4'b1000, 6'd3},
    {4'b1111, 1'b0, 2'd0, 6'd0, 4'b0001, 6'd4},
    {4'b0000, 1'b1, 2'd0, 6'd4, 4'b0000, 6'd0},
    {4'b0010, 1'b0, 2'd0, 6'd0, 4'b0010, 6'd4},
    {4'b0001, 1'b1, 2'd1, 6'd1, 4'b0001, 6'd5},
    {4'b1000, 1'b0, 2'd0, 6'd0, 4'b1000, 6'd1}
  };

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_i = '0; big_en_i = '0; rel_valid_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_ready();
    int n = 0;
    while (!ready_o && n < 200) begin @(negedge clk); n++; end
  endtask

  // Hold a request from port p for n cycles and count its grants.
  task automatic hold_req(input int p, input int n, output int grants);
    grants = 0;
    req_i[p] = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gnt_o[p]) grants++;
    end
  endtask

  initial begin
    int g;
    int init_cycles;
    // R1: reset and initialization sweep
    do_reset();
    req_i = 4'b0001;
    @(negedge clk);
    check("R1 ready low after reset", ready_o, 0);
    check("R1 no grant in init", gnt_o, 0);
    check("R1 no fc in init", fc_o, 0);
    req_i = '0;
    init_cycles = 1;
    while (!ready_o && init_cycles < 200) begin @(negedge clk); init_cycles++; end
    check("R1 free count after init", free_count_o, 64);
    check("R1 sweep length", (init_cycles >= 64 && init_cycles <= 66) ? 1 : 0, 1);

    // Table: R2 R3 R4 R8 R9
    for (int v = 0; v < 9; v++) begin
      logic [22:0] e;
      e = VEC[v];
      req_i = e[22:19]; rel_valid_i = e[18]; rel_port_i = e[17:16];
      rel_handle_i = e[15:10];
      @(negedge clk);
      check($sformatf("R3/R4 grant vector %0d", v), gnt_o, e[9:6]);
      if (e[9:6] != 0)
        check($sformatf("R2/R9 handle vector %0d", v), gnt_handle_o, e[5:0]);
    end
    req_i = '0; rel_valid_i = 1'b0;
    @(negedge clk);
    check("R8 R9 free count after table", free_count_o, 58);

    // R5: standard and oversized limits
    do_reset(); wait_ready();
    hold_req(0, 20, g);
    check("R5 standard limit grants", g, 12);
    check("R7 fc at limit", fc_o[0], 1);
    big_en_i[0] = 1'b1;
    hold_req(0, 30, g);
    check("R5 oversized limit grants", g, 20);
    req_i = '0;
    @(negedge clk);
    check("R7 fc clears", fc_o, 0);
    check("R5 free count", free_count_o, 32);

    // R6: reserve floor
    big_en_i[1] = 1'b1;
    hold_req(1, 40, g);
    check("R6 grants down to reserve", g, 24);
    check("R7 fc at reserve", fc_o[1], 1);
    req_i = '0;
    hold_req(2, 5, g);
    check("R6 idle port served from reserve", g, 1);
    check("R7 fc after reserve grant", fc_o[2], 1);
    req_i = '0;
    @(negedge clk);
    check("R6 free count", free_count_o, 7);

    // R10: release when full
    do_reset(); wait_ready();
    rel_valid_i = 1'b1; rel_port_i = 2'd0; rel_handle_i = 6'd5;
    @(negedge clk);
    rel_valid_i = 1'b0;
    check("R10 err set", err_o, 1);
    check("R10 count unchanged", free_count_o, 64);
    req_i = 4'b0001;
    @(negedge clk);
    req_i = '0;
    check("R10 list unchanged", gnt_handle_o, 0);
    repeat (3) @(negedge clk);
    check("R10 err sticky", err_o, 1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule